// File: doc/BRIEF.md
# Idle-Cycle Activity Log Buffer

This block is a trace buffer that sits next to monitored pipeline logic. It takes one fixed-width activity record per cycle. It packs consecutive records into cache-line-sized lines and queues complete lines in a small drain FIFO. Each line is written into a log region in main memory. The write goes through the data cache write port, and only in cycles when the cache has no demand access of its own. Software sets the region by loading a base and a limit, both in line units. When the write pointer reaches the limit, the block raises a request for more space and holds its queued lines until a new region is loaded.

Two interfaces use valid/ready handshakes.

- Record input (`rec_valid`/`rec_ready`): a record transfers on a rising edge where both signals are high. In stall mode, `rec_ready` falls only when a record would complete a line while the drain FIFO is full. In drop mode, `rec_ready` stays high in that case, the completed line is discarded, and a saturating drop counter increases. In both modes, `rec_ready` is low while a flush is being handled.
- Line output (`wr_valid`/`wr_ready`): a line transfers on a rising edge where both signals are high. `wr_valid` is only offered while `cache_busy` is low. It may be withdrawn without a transfer when a demand access appears, because the port is shared with demand traffic.

A flush pulse forces a partially filled line out. The line is padded with zeros and tagged with its number of valid records.

Top module: `actlog_buffer`

## Requirements
- R1: While the buffer has room, `rec_ready` is high every cycle and records transfer back to back. The k-th record of a line (k counted from 0) occupies bits [k*REC_W +: REC_W] of `wr_data`.
- R2: A line filled by LINE_RECS records is written with `wr_count` equal to LINE_RECS. Lines leave in the order in which they were filled.
- R3: `wr_valid` is never high in a cycle in which `cache_busy` is high.
- R4: A pulse on `cfg_load` sets the write address to `cfg_base`. Each accepted line write then increases `wr_addr` by exactly one.
- R5: When the write address equals the loaded limit, `need_space` is high and no line is offered. After a new base and limit are loaded, writing resumes at the new base.
- R6: In stall mode (`stall_mode`=1), a record that would complete a line while the drain FIFO is full is refused (`rec_ready` low). No line is lost.
- R7: In drop mode (`stall_mode`=0), `rec_ready` stays high when a line completes while the FIFO is full. That line is discarded and `drop_count` increases by one, saturating at its maximum.
- R8: A `flush` pulse with a partial line pending emits that line, with `wr_count` equal to its number of valid records and all unused record slots zero. `rec_ready` is low in the flush cycle and until the line is emitted. A flush with no pending record emits nothing.
- R9: After reset, `rec_ready` is high, `wr_valid` is low, `need_space` is high (base and limit both zero), and `drop_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall_mode | input | 1 | 1: back-pressure on a full FIFO, 0: drop the line |
| rec_valid | input | 1 | Record offered |
| rec_ready | output | 1 | Record can be taken |
| rec_data | input | REC_W | Activity record |
| flush | input | 1 | Force out the partial line |
| cfg_load | input | 1 | Load a new region base and limit |
| cfg_base | input | ADDR_W | Region start, in lines |
| cfg_limit | input | ADDR_W | Region end (exclusive), in lines |
| need_space | output | 1 | Write pointer has reached the limit |
| cache_busy | input | 1 | Cache port has a demand access this cycle |
| wr_valid | output | 1 | Line write offered |
| wr_ready | input | 1 | Cache accepts the line write |
| wr_addr | output | ADDR_W | Line address of the write |
| wr_data | output | REC_W*LINE_RECS | Packed line |
| wr_count | output | $clog2(LINE_RECS+1) | Valid records in the line |
| drop_count | output | CNT_W | Saturating count of dropped lines |

## Verification
The bench streams record sequences under four conditions, each of which separates different failures:

- Back-to-back records with a pseudo-random `cache_busy` pattern. This exposes wrong slot order and writes issued during demand accesses.
- Short bursts ended by a flush, plus a flush with nothing pending. These separate padding and count errors from spurious empty lines.
- Long bursts with `wr_ready` held low, run in both modes. The same overflow point must give back-pressure with no loss in stall mode, and exactly one counted drop with no stall in drop mode.
- A small region that fills after two lines. This checks the stop at the limit and the restart at a newly loaded base.

// File: rtl/actlog_pkg.sv
`timescale 1ns/1ps
package actlog_pkg;
  typedef enum logic {
    OVF_DROP  = 1'b0,
    OVF_STALL = 1'b1
  } ovf_mode_e;

  localparam int unsigned DEF_REC_W     = 16;
  localparam int unsigned DEF_LINE_RECS = 4;
  localparam int unsigned DEF_FIFO_D    = 4;
  localparam int unsigned DEF_ADDR_W    = 16;
  localparam int unsigned DEF_CNT_W     = 8;
endpackage

// File: rtl/alb_packer.sv
`timescale 1ns/1ps
module alb_packer
  import actlog_pkg::*;
#(
  parameter int unsigned REC_W     = DEF_REC_W,
  parameter int unsigned LINE_RECS = DEF_LINE_RECS,
  parameter int unsigned CNT_W     = DEF_CNT_W,
  localparam int unsigned LINE_W   = REC_W * LINE_RECS,
  localparam int unsigned FILL_W   = $clog2(LINE_RECS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_mode,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [REC_W-1:0]  rec_data,
  input  logic              flush,
  input  logic              fifo_full,
  output logic              push,
  output logic [LINE_W-1:0] push_line,
  output logic [FILL_W-1:0] push_cnt,
  output logic [CNT_W-1:0]  drop_count
);
  ovf_mode_e          mode;
  logic [REC_W-1:0]   slot_q [LINE_RECS];
  logic [FILL_W-1:0]  fill_q;
  logic               pend_q;
  logic               last_slot;
  logic               acc;
  logic               emit;
  logic               drop;
  logic               hold_full;

  assign mode      = ovf_mode_e'(stall_mode);
  assign last_slot = (fill_q == FILL_W'(LINE_RECS - 1));
  assign hold_full = (mode == OVF_STALL) && fifo_full;
  assign rec_ready = !pend_q && !flush && !(hold_full && last_slot);
  assign acc       = rec_valid && rec_ready;
  assign emit      = (acc && last_slot) || (pend_q && !hold_full);
  assign push      = emit && !fifo_full;
  assign drop      = emit && fifo_full;
  assign push_cnt  = acc ? FILL_W'(fill_q + 1'b1) : fill_q;

  // The line leaving this cycle already contains a record accepted this cycle.
  for (genvar gi = 0; gi < LINE_RECS; gi++) begin : g_slot
    assign push_line[gi*REC_W +: REC_W] =
      (acc && fill_q == FILL_W'(gi)) ? rec_data : slot_q[gi];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[gi] <= '0;
      end else if (emit) begin
        slot_q[gi] <= '0;
      end else if (acc && fill_q == FILL_W'(gi)) begin
        slot_q[gi] <= rec_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      pend_q <= 1'b0;
    end else if (emit) begin
      fill_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (acc) begin
        fill_q <= FILL_W'(fill_q + 1'b1);
      end
      if (flush && fill_q != '0) begin
        pend_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_count <= '0;
    end else if (drop && drop_count != '1) begin
      drop_count <= drop_count + 1'b1;
    end
  end

  p_fill_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q < FILL_W'(LINE_RECS));

  p_no_drop_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_mode && emit) |-> !fifo_full);

  p_drop_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && drop_count != '1) |=> (drop_count == $past(drop_count) + 1'b1));

  p_flush_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && fill_q != '0 && !emit) |=> !rec_ready);
endmodule

// File: rtl/alb_fifo.sv
`timescale 1ns/1ps
module alb_fifo #(
  parameter int unsigned WIDTH = 67,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [OCC_W-1:0] occ;

  assign full  = (occ == OCC_W'(DEPTH));
  assign empty = (occ == '0);
  assign head  = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(p + 1'b1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/alb_drain.sv
`timescale 1ns/1ps
module alb_drain #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  input  logic              cache_busy,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  output logic              need_space,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              pop
);
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] lim_q;

  assign need_space = (ptr_q >= lim_q);
  assign wr_valid   = !fifo_empty && !cache_busy && !need_space && !cfg_load;
  assign wr_addr    = ptr_q;
  assign pop        = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      lim_q <= '0;
    end else if (cfg_load) begin
      ptr_q <= cfg_base;
      lim_q <= cfg_limit;
    end else if (pop) begin
      ptr_q <= ptr_q + ADDR_W'(1);
    end
  end

  p_idle_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cache_busy |-> !wr_valid);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

  p_cfg_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (wr_addr == $past(cfg_base)));

  p_limit_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    need_space |-> !pop);
endmodule

// File: rtl/actlog_buffer.sv
`timescale 1ns/1ps
module actlog_buffer
  import actlog_pkg::*;
#(
  parameter int unsigned REC_W     = DEF_REC_W,
  parameter int unsigned LINE_RECS = DEF_LINE_RECS,
  parameter int unsigned FIFO_D    = DEF_FIFO_D,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned CNT_W     = DEF_CNT_W,
  localparam int unsigned LINE_W   = REC_W * LINE_RECS,
  localparam int unsigned FILL_W   = $clog2(LINE_RECS + 1),
  localparam int unsigned ENT_W    = LINE_W + FILL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_mode,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [REC_W-1:0]  rec_data,
  input  logic              flush,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  output logic              need_space,
  input  logic              cache_busy,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LINE_W-1:0] wr_data,
  output logic [FILL_W-1:0] wr_count,
  output logic [CNT_W-1:0]  drop_count
);
  logic              push;
  logic [LINE_W-1:0] push_line;
  logic [FILL_W-1:0] push_cnt;
  logic              fifo_full;
  logic              fifo_empty;
  logic              pop;
  logic [ENT_W-1:0]  head;

  alb_packer #(
    .REC_W(REC_W), .LINE_RECS(LINE_RECS), .CNT_W(CNT_W)
  ) u_packer (
    .clk(clk), .rst_n(rst_n), .stall_mode(stall_mode),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
    .flush(flush), .fifo_full(fifo_full), .push(push),
    .push_line(push_line), .push_cnt(push_cnt), .drop_count(drop_count)
  );

  alb_fifo #(
    .WIDTH(ENT_W), .DEPTH(FIFO_D)
  ) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push),
    .push_data({push_cnt, push_line}), .pop(pop),
    .head(head), .full(fifo_full), .empty(fifo_empty)
  );

  alb_drain #(
    .ADDR_W(ADDR_W)
  ) u_drain (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty),
    .cache_busy(cache_busy), .cfg_load(cfg_load), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .need_space(need_space), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .pop(pop)
  );

  assign wr_data  = head[LINE_W-1:0];
  assign wr_count = head[ENT_W-1:LINE_W];
endmodule

// File: tb/tb_actlog_buffer.sv
`timescale 1ns/1ps
module tb_actlog_buffer;
  localparam int REC_W  = 16;
  localparam int LRECS  = 4;
  localparam int FDEPTH = 4;
  localparam int AW     = 16;
  localparam int CW     = 8;
  localparam int LW     = REC_W * LRECS;
  localparam int FW     = $clog2(LRECS + 1);

  logic clk = 0;
  logic rst_n = 0;
  logic stall_mode = 1;
  logic rec_valid = 0;
  logic rec_ready;
  logic [REC_W-1:0] rec_data = '0;
  logic flush = 0;
  logic cfg_load = 0;
  logic [AW-1:0] cfg_base = '0;
  logic [AW-1:0] cfg_limit = '0;
  logic need_space;
  logic cache_busy = 0;
  logic wr_valid;
  logic wr_ready = 1;
  logic [AW-1:0] wr_addr;
  logic [LW-1:0] wr_data;
  logic [FW-1:0] wr_count;
  logic [CW-1:0] drop_count;

  always #5 clk = ~clk;

  actlog_buffer #(
    .REC_W(REC_W), .LINE_RECS(LRECS), .FIFO_D(FDEPTH), .ADDR_W(AW), .CNT_W(CW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .stall_mode(stall_mode), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_data(rec_data), .flush(flush),
    .cfg_load(cfg_load), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .need_space(need_space), .cache_busy(cache_busy), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_count(wr_count), .drop_count(drop_count)
  );

  int total = 0;
  int bad = 0;
  logic [LW-1:0] q_data[$];
  logic [FW-1:0] q_cnt[$];
  logic [AW-1:0] exp_addr = '0;
  logic [LW-1:0] bm_line = '0;
  int bm_fill = 0;
  bit keep = 1;
  bit busy_en = 0;
  int stalls = 0;
  logic [7:0] lfsr = 8'h5A;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // demand traffic on the cache port
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cache_busy <= busy_en ? lfsr[0] : 1'b0;
  end

  // monitor: compares each written line with the scoreboard
  initial begin
    forever begin
      @(negedge clk); #2;
      if (wr_valid && cache_busy)
        check(0, "R3", "wr_valid during demand access", 1, 0);
      if (wr_valid && wr_ready) begin
        if (q_data.size() == 0) begin
          check(0, "R8", "unexpected line", {48'h0, wr_addr}, 0);
        end else begin
          logic [LW-1:0] ed;
          logic [FW-1:0] ec;
          ed = q_data.pop_front();
          ec = q_cnt.pop_front();
          check(wr_data == ed, "R1", "line data", wr_data, ed);
          check(wr_count == ec, "R2", "line count", 64'(wr_count), 64'(ec));
          check(wr_addr == exp_addr, "R4", "line addr", 64'(wr_addr), 64'(exp_addr));
        end
        exp_addr = exp_addr + 1'b1;
      end
    end
  end

  task automatic send(input logic [REC_W-1:0] d);
    @(negedge clk);
    rec_valid = 1;
    rec_data = d;
    #1;
    while (!rec_ready) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(posedge clk);
    bm_line[bm_fill*REC_W +: REC_W] = d;
    bm_fill++;
    if (bm_fill == LRECS) begin
      if (keep) begin
        q_data.push_back(bm_line);
        q_cnt.push_back(FW'(LRECS));
      end
      bm_line = '0;
      bm_fill = 0;
    end
  endtask

  task automatic idle_in();
    @(negedge clk);
    rec_valid = 0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    rec_valid = 0;
    flush = 1;
    #1;
    check(rec_ready == 0, "R8", "rec_ready in flush cycle", 64'(rec_ready), 0);
    if (bm_fill > 0) begin
      q_data.push_back(bm_line);
      q_cnt.push_back(FW'(bm_fill));
    end
    bm_line = '0;
    bm_fill = 0;
    @(negedge clk);
    flush = 0;
  endtask

  task automatic config_region(input logic [AW-1:0] b, input logic [AW-1:0] l);
    @(negedge clk);
    cfg_load = 1;
    cfg_base = b;
    cfg_limit = l;
    exp_addr = b;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic drain_wait(input string req);
    for (int i = 0; i < 400 && q_data.size() != 0; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    check(q_data.size() == 0, req, "lines left in scoreboard", 64'(q_data.size()), 0);
  endtask

  initial begin
    #2_000_000;
    check(0, "WD", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    // R9 reset state
    check(rec_ready == 1, "R9", "rec_ready after reset", 64'(rec_ready), 1);
    check(wr_valid == 0, "R9", "wr_valid after reset", 64'(wr_valid), 0);
    check(need_space == 1, "R9", "need_space after reset", 64'(need_space), 1);
    check(drop_count == 0, "R9", "drop_count after reset", 64'(drop_count), 0);

    // R1/R2/R3: back-to-back records with random demand traffic
    config_region(16'h0100, 16'h0200);
    busy_en = 1;
    stalls = 0;
    for (int i = 0; i < 12; i++) send(16'h1000 + 16'(i));
    idle_in();
    check(stalls == 0, "R1", "stalls on streaming input", 64'(stalls), 0);
    drain_wait("R2");

    // R8: partial flush and empty flush
    send(16'hAAAA);
    send(16'hBBBB);
    idle_in();
    do_flush();
    drain_wait("R8");
    do_flush();
    repeat (10) @(negedge clk);
    #2;
    check(wr_valid == 0, "R8", "line after empty flush", 64'(wr_valid), 0);

    // R6: stall mode back-pressure without loss
    busy_en = 0;
    wr_ready = 0;
    stalls = 0;
    fork
      begin
        for (int i = 0; i < 20; i++) send(16'h2000 + 16'(i));
        idle_in();
      end
      begin
        repeat (40) @(negedge clk);
        wr_ready = 1;
      end
    join
    check(stalls > 0, "R6", "back-pressure seen", 64'(stalls), 1);
    drain_wait("R6");

    // R7: drop mode
    stall_mode = 0;
    wr_ready = 0;
    stalls = 0;
    for (int i = 0; i < 20; i++) begin
      keep = (i < 16);
      send(16'h3000 + 16'(i));
    end
    idle_in();
    keep = 1;
    repeat (2) @(negedge clk);
    #2;
    check(stalls == 0, "R7", "stalls in drop mode", 64'(stalls), 0);
    check(drop_count == 1, "R7", "drop_count", 64'(drop_count), 1);
    wr_ready = 1;
    drain_wait("R7");
    stall_mode = 1;

    // R5: limit stop and restart at new base
    config_region(16'h0010, 16'h0012);
    for (int i = 0; i < 12; i++) send(16'h4000 + 16'(i));
    idle_in();
    repeat (20) @(negedge clk);
    #2;
    check(need_space == 1, "R5", "need_space at limit", 64'(need_space), 1);
    check(wr_valid == 0, "R5", "wr_valid at limit", 64'(wr_valid), 0);
    check(q_data.size() == 1, "R5", "lines held", 64'(q_data.size()), 1);
    config_region(16'h0040, 16'h0050);
    #2;
    check(need_space == 0, "R5", "need_space after reload", 64'(need_space), 0);
    drain_wait("R5");
    check(exp_addr == 16'h0041, "R4", "address after restart", 64'(exp_addr), 64'h41);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule